// File: doc/BRIEF.md
# Watchdog Timer with Assignable Prescaler

The block is a watchdog that advances on a slow, free-running tick which is independent of the processor clock, so it keeps timing while the core is asleep. A base counter expires after a parameterised number of counting steps. An optional prescaler can be placed in front of it under software control, and it stretches the period by a power of two up to 1:128. A static enable input turns the whole watchdog off.

Software restarts the watchdog with a clear strobe. Entering sleep restarts it too, so the full period is available before a wake-up. Each restart zeroes the base counter, and it zeroes the prescaler as well when the prescaler is assigned. An expiry while awake gives a device-reset pulse. An expiry while asleep gives a wake-up pulse. Either kind of expiry lowers a time-out status flag. Power-on, a clear strobe or sleep entry raises that flag again.

The unit is clocked by a sampling clock. `tick` is a one-cycle enable that marks each edge of the slow oscillator. All strobes are synchronous to `clk`.

Top module: `wdog_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `timeoutFlag` is 1 and `devReset` and `wakeReset` are 0.
- R2: With the prescaler unassigned (`prescOn`=0) and `asleep`=0, the BASE_TICKS-th tick after a restart gives a `devReset` pulse that is exactly one `clk` cycle wide. BASE_TICKS-1 ticks give no pulse.
- R3: With `prescOn`=1, `ratioSel` picks a ratio of 2^ratioSel: 0 is 1:1 and 7 is 1:128. Expiry then takes BASE_TICKS*2^ratioSel ticks after a restart.
- R4: When `prescOn`=0, `ratioSel` has no effect and the period stays BASE_TICKS ticks.
- R5: A `clrStrobe` zeroes the base counter and, when assigned, the prescaler. No expiry can occur until a full period of ticks after the strobe.
- R6: A `sleepEntry` strobe restarts the watchdog in the same way as R5. An expiry while `asleep`=1 gives a one-cycle `wakeReset` pulse and no `devReset`.
- R7: An expiry drives `timeoutFlag` to 0 in the same cycle as its pulse. A `clrStrobe` or a `sleepEntry` sets the flag to 1 on the following edge.
- R8: With `wdtEnable`=0, ticks are not counted and neither pulse is ever produced.
- R9: A restart strobe wins over a tick in the same cycle, and that tick is not counted.
- R10: After an expiry the counter starts again from zero, so the next expiry comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-cycle strobe per slow-oscillator tick |
| clrStrobe | input | 1 | Clear-watchdog strobe from the core |
| sleepEntry | input | 1 | Strobe on entry into sleep |
| asleep | input | 1 | Core is in sleep |
| prescOn | input | 1 | Prescaler assigned to the watchdog |
| ratioSel | input | RATIO_W | Prescaler ratio exponent (ratio 2^ratioSel) |
| wdtEnable | input | 1 | Static enable fuse |
| devReset | output | 1 | One-cycle device-reset pulse on an expiry while awake |
| wakeReset | output | 1 | One-cycle wake-up pulse on an expiry while asleep |
| timeoutFlag | output | 1 | Time-out status; 0 after an expiry |

## Verification
The expiring tick is sampled at a rising edge, and the pulse and the flag change are registered at that same edge, so both are visible one clock later. The bench drives each tick high for one cycle and then low for one cycle. It reads the pulse counters and the flag only after the falling edge that follows the low cycle, by which point any pulse caused by the last tick has already been seen. Each scenario first checks that period-minus-one ticks give no pulse, then gives one more tick and checks that exactly one pulse appears. A restart strobe takes effect at the next edge, so the flag is read one cycle after the strobe.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes from the control part to the counting datapath
  typedef struct packed {
    logic advance;     // count one tick
    logic clearCnt;    // zero the base counter
    logic clearPresc;  // zero the prescaler
  } wdogCtl_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 18,
  parameter int RATIO_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wdogCtl_t           ctl,
  input  logic               prescOn,
  input  logic [RATIO_W-1:0] ratioSel,
  output logic               expire
);

  localparam int PRESC_BITS = (1 << RATIO_W) - 1;
  localparam int CNT_W      = (BASE_TICKS > 1) ? $clog2(BASE_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BASE_TICKS - 1);

  logic [PRESC_BITS-1:0] prescCnt;
  logic [PRESC_BITS-1:0] prescMask;
  logic [CNT_W-1:0]      mainCnt;
  logic                  prescWrap;
  logic                  step;

  // Thermometer mask: the low ratioSel bits must all be set for a carry
  for (genvar i = 0; i < PRESC_BITS; i++) begin : g_mask
    assign prescMask[i] = (32'(ratioSel) > i);
  end

  always_comb begin
    prescWrap = prescOn ? ((prescCnt & prescMask) == prescMask) : 1'b1;
    step      = ctl.advance & prescWrap;
    expire    = step & (mainCnt == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescCnt <= '0;
    end else if (ctl.clearPresc) begin
      prescCnt <= '0;
    end else if (ctl.advance && prescOn) begin
      prescCnt <= prescWrap ? '0 : prescCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mainCnt <= '0;
    end else if (ctl.clearCnt) begin
      mainCnt <= '0;
    end else if (step) begin
      mainCnt <= expire ? '0 : mainCnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     clrStrobe,
  input  logic     sleepEntry,
  input  logic     asleep,
  input  logic     prescOn,
  input  logic     wdtEnable,
  input  logic     expire,
  output wdogCtl_t ctl,
  output logic     devReset,
  output logic     wakeReset,
  output logic     timeoutFlag
);

  logic restart;

  always_comb begin
    restart        = clrStrobe | sleepEntry;
    ctl.advance    = tick & wdtEnable & ~restart;
    ctl.clearCnt   = restart;
    ctl.clearPresc = restart & prescOn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devReset    <= 1'b0;
      wakeReset   <= 1'b0;
      timeoutFlag <= 1'b1;
    end else begin
      devReset  <= expire & ~asleep;
      wakeReset <= expire & asleep;
      if (restart)     timeoutFlag <= 1'b1;
      else if (expire) timeoutFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/wdog_unit.sv
module wdog_unit
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 18,
  parameter int RATIO_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               clrStrobe,
  input  logic               sleepEntry,
  input  logic               asleep,
  input  logic               prescOn,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic               wdtEnable,
  output logic               devReset,
  output logic               wakeReset,
  output logic               timeoutFlag
);

  wdogCtl_t ctl;
  logic     expire;

  wdog_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .clrStrobe  (clrStrobe),
    .sleepEntry (sleepEntry),
    .asleep     (asleep),
    .prescOn    (prescOn),
    .wdtEnable  (wdtEnable),
    .expire     (expire),
    .ctl        (ctl),
    .devReset   (devReset),
    .wakeReset  (wakeReset),
    .timeoutFlag(timeoutFlag)
  );

  wdog_datapath #(
    .BASE_TICKS(BASE_TICKS),
    .RATIO_W   (RATIO_W)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .prescOn (prescOn),
    .ratioSel(ratioSel),
    .expire  (expire)
  );

endmodule

// File: rtl/wdog_unit_chk.sv
module wdog_unit_chk #(
  parameter int RATIO_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               clrStrobe,
  input logic               sleepEntry,
  input logic               asleep,
  input logic               prescOn,
  input logic [RATIO_W-1:0] ratioSel,
  input logic               wdtEnable,
  input logic               devReset,
  input logic               wakeReset,
  input logic               timeoutFlag
);

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(devReset && wakeReset)); // R6

  AST_DEV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    devReset |=> !devReset); // R2

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wakeReset |=> !wakeReset); // R6

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wakeReset |-> $past(asleep)); // R6

  AST_DEV_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    devReset |-> !$past(asleep)); // R2

  AST_FLAG_LOW_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (devReset || wakeReset) |-> !timeoutFlag); // R7

  AST_RESTART_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clrStrobe || sleepEntry) |=> timeoutFlag); // R7

  AST_RESTART_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (clrStrobe || sleepEntry) |=> (!devReset && !wakeReset)); // R9

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !wdtEnable |=> (!devReset && !wakeReset)); // R8

endmodule

bind wdog_unit wdog_unit_chk #(.RATIO_W(RATIO_W)) chk_i (.*);

// File: tb/wdog_unit_tb_top.sv
module wdog_unit_tb_top;

  localparam int BT = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       clrStrobe = 1'b0;
  logic       sleepEntry = 1'b0;
  logic       asleep = 1'b0;
  logic       prescOn = 1'b0;
  logic [2:0] ratioSel = 3'd0;
  logic       wdtEnable = 1'b1;
  logic       devReset;
  logic       wakeReset;
  logic       timeoutFlag;

  int errors = 0;
  int checks = 0;
  int devCnt = 0;
  int wakeCnt = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  wdog_unit #(.BASE_TICKS(BT), .RATIO_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clrStrobe(clrStrobe),
    .sleepEntry(sleepEntry), .asleep(asleep), .prescOn(prescOn),
    .ratioSel(ratioSel), .wdtEnable(wdtEnable), .devReset(devReset),
    .wakeReset(wakeReset), .timeoutFlag(timeoutFlag)
  );

  always @(negedge clk) begin
    if (rst_n && devReset)  devCnt++;
    if (rst_n && wakeReset) wakeCnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=%0d cycles", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulseClr();
    clrStrobe = 1'b1;
    @(negedge clk);
    clrStrobe = 1'b0;
    @(negedge clk);
  endtask

  // Checks that period-1 ticks give nothing and one more gives one devReset
  task automatic expectDevAfter(input int period, input string req);
    int d0, w0;
    d0 = devCnt; w0 = wakeCnt;
    runTicks(period - 1);
    check(devCnt == d0, {req, " early"}, devCnt - d0, 0);
    runTicks(1);
    check(devCnt == d0 + 1, {req, " expiry"}, devCnt - d0, 1);
    check(wakeCnt == w0, {req, " no wake"}, wakeCnt - w0, 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(timeoutFlag == 1'b1, "R1 flag in reset", timeoutFlag, 1);
    check(!devReset && !wakeReset, "R1 pulses in reset", devReset | wakeReset, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(timeoutFlag == 1'b1, "R1 flag after reset", timeoutFlag, 1);
  endtask

  task automatic testBase();
    prescOn = 1'b0; ratioSel = 3'd0;
    pulseClr();
    expectDevAfter(BT, "R2 base period");
    check(timeoutFlag == 1'b0, "R7 flag cleared by expiry", timeoutFlag, 0);
    expectDevAfter(BT, "R10 second period");
    pulseClr();
    check(timeoutFlag == 1'b1, "R7 flag set by clear", timeoutFlag, 1);
  endtask

  task automatic testIgnoreRatio();
    prescOn = 1'b0; ratioSel = 3'd7;
    pulseClr();
    expectDevAfter(BT, "R4 ratio ignored");
  endtask

  task automatic testPresc();
    prescOn = 1'b1; ratioSel = 3'd3;
    pulseClr();
    expectDevAfter(BT * 8, "R3 ratio 1:8");
    ratioSel = 3'd7;
    pulseClr();
    expectDevAfter(BT * 128, "R3 ratio 1:128");
  endtask

  task automatic testClear();
    prescOn = 1'b1; ratioSel = 3'd2;
    pulseClr();
    runTicks(BT * 4 - 3);
    pulseClr();
    expectDevAfter(BT * 4, "R5 clear restarts");
  endtask

  task automatic testSameCycle();
    prescOn = 1'b0; ratioSel = 3'd0;
    pulseClr();
    runTicks(3);
    clrStrobe = 1'b1; tick = 1'b1;
    @(negedge clk);
    clrStrobe = 1'b0; tick = 1'b0;
    @(negedge clk);
    expectDevAfter(BT, "R9 clear beats tick");
  endtask

  task automatic testSleep();
    int d0, w0;
    prescOn = 1'b1; ratioSel = 3'd1;
    pulseClr();
    runTicks(3);
    asleep = 1'b1;
    sleepEntry = 1'b1;
    @(negedge clk);
    sleepEntry = 1'b0;
    @(negedge clk);
    check(timeoutFlag == 1'b1, "R7 flag after sleep entry", timeoutFlag, 1);
    d0 = devCnt; w0 = wakeCnt;
    runTicks(BT * 2 - 1);
    check(wakeCnt == w0, "R6 sleep early", wakeCnt - w0, 0);
    runTicks(1);
    check(wakeCnt == w0 + 1, "R6 wake pulse", wakeCnt - w0, 1);
    check(devCnt == d0, "R6 no device reset asleep", devCnt - d0, 0);
    check(timeoutFlag == 1'b0, "R7 flag cleared by wake", timeoutFlag, 0);
    asleep = 1'b0;
    sleepEntry = 1'b1;
    @(negedge clk);
    sleepEntry = 1'b0;
    @(negedge clk);
    check(timeoutFlag == 1'b1, "R7 sleep entry sets flag", timeoutFlag, 1);
  endtask

  task automatic testDisabled();
    int d0, w0;
    wdtEnable = 1'b0; prescOn = 1'b0;
    pulseClr();
    d0 = devCnt; w0 = wakeCnt;
    runTicks(BT * 3);
    check(devCnt == d0 && wakeCnt == w0, "R8 disabled no pulse",
          (devCnt - d0) + (wakeCnt - w0), 0);
    check(timeoutFlag == 1'b1, "R8 disabled flag held", timeoutFlag, 1);
  endtask

  initial begin
    testReset();
    testBase();
    testIgnoreRatio();
    testPresc();
    testClear();
    testSameCycle();
    testSleep();
    testDisabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule